// File: doc/BRIEF.md
# Dual-Channel Wiper Register Bank with Emulated Persistent Storage

This block is the register file that sits behind a serial-peripheral frontend and sets two 8-bit resistor-ladder wiper codes. Each channel has a live wiper register, which drives the wiper code output, and a persistent start-up register, which supplies the code loaded at power-up. Thirteen persistent general-purpose bytes sit beside them, along with one reserved location and a control register.

The frontend hands over one decoded request at a time: a one-cycle pulse with direction, a 5-bit address and a data byte, issued when the chip select rises. The bank answers in the next cycle with a response valid, a refused flag and read data. The control register has a bank-select bit, which chooses whether addresses 00h and 01h reach the live or the persistent registers. It also holds an active-low run bit, a write-in-progress flag and an output-type bit.

A persistent write copies its value into the live register and then makes the bank busy for a set number of clock cycles. This stands in for the erase/program time of a real memory cell. A power-good input holds the wipers at mid-scale while the supply is low. When the supply comes back, the bank reloads each wiper from its stored start-up value.

Top module: `wiper_regbank`

## Requirements
- R1: After reset, both wiper codes are 80h, both shutdown flags are 0, the output-type flag is 0 and a control register read (address 10h) returns 40h.
- R2: With the bank-select bit (control bit 7) at 1, reads and writes to address 00h and 01h reach only the live register of channel 0 and 1. The wiper code follows the write with no busy period, and codes 00h and FFh pass through unchanged.
- R3: With the bank-select bit at 0, a write to address 00h or 01h stores the byte in that channel's start-up register and also in its live register. It then starts a busy period.
- R4: The write-in-progress flag (control bit 5) reads 1 for exactly BUSY_CYCLES clock cycles after the cycle in which a persistent write is accepted. Writes to it are ignored.
- R5: While busy, every request except a read of the control register is refused. A refused request changes no register and no output.
- R6: Addresses 02h to 0Eh are persistent general-purpose bytes. They are usable only with the bank-select bit at 0, and a write to one starts a busy period. With the bank-select bit at 1 they are refused.
- R7: Address 0Fh and addresses 11h to 1Fh read as 00h, and writes to them are accepted without effect.
- R8: Control layout: bit 7 bank-select, bit 6 run (active low shutdown), bit 5 write-in-progress, bit 1 output type (1 = open drain, driven on sdo_open_drain). Bits 4, 3, 2 and 0 read 0.
- R9: With the run bit at 0, both shutdown flags are 1 and both wiper codes are 00h. Setting it back to 1 restores the codes held in the live registers.
- R10: While power-good is 0, both live registers are forced to 80h and every request is refused. After power-good rises, each live register is reloaded from its start-up register.
- R11: With the bank-select bit at 0, a read of address 00h or 01h returns the start-up value and leaves the live register and wiper code unchanged.
- R12: Every request gets exactly one response pulse in the next cycle. A refused read returns data 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good indication; low holds wipers at mid-scale |
| req_valid | input | 1 | One-cycle request pulse from the serial frontend |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (5) | Register address |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after each request |
| rsp_refused | output | 1 | Request was refused (busy, power-down or bank-select) |
| rsp_data | output | DW (8) | Read data, 00h for writes and refused reads |
| wiper_code | output | NCH*DW (16) | Wiper codes, channel i at bits [i*DW +: DW] |
| shdn | output | NCH (2) | Per-channel shutdown flag |
| sdo_open_drain | output | 1 | Selected serial output type, 1 = open drain |

## Verification
A live register that is wrong shows on the wiper code two cycles after the request that should have set it. A wrong start-up register stays hidden until the next read with the bank-select bit at 0, or until a power-good cycle recalls it. A busy counter that is off by one shows as a write-in-progress bit that changes one read too early or too late. It also shows as one access refused or accepted wrongly at the edge of the window, so the busy boundary is polled cycle by cycle against a reference model.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  // Writable control fields; write-in-progress is supplied from the timer
  typedef struct packed {
    logic vol;   // bank select: 1 = live wiper registers only
    logic run;   // active-low shutdown
    logic od;    // serial output type
  } acr_t;

  localparam acr_t ACR_RESET = '{vol: 1'b0, run: 1'b1, od: 1'b0};

  function automatic logic [7:0] acr_pack(acr_t a, logic wip);
    return {a.vol, a.run, wip, 3'b000, a.od, 1'b0};
  endfunction

endpackage

// File: rtl/wrb_nv_store.sv
module wrb_nv_store #(
  parameter int DW = 8,
  parameter int NCH = 2,
  parameter int NGP = 13,
  parameter int GIW = 4,
  parameter logic [DW-1:0] IVR_RESET = 8'h80
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      ivr_we,
  input  logic                gp_we,
  input  logic [GIW-1:0]      gp_idx,
  input  logic [DW-1:0]       wdata,
  output logic [NCH*DW-1:0]   ivr_flat,
  output logic [DW-1:0]       gp_rdata
);

  logic [DW-1:0] gp_mem [NGP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NGP; i++) gp_mem[i] <= '0;
    end else if (gp_we) begin
      gp_mem[gp_idx] <= wdata;
    end
  end

  assign gp_rdata = (int'(gp_idx) < NGP) ? gp_mem[gp_idx] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ivr
    logic [DW-1:0] ivr_q;
    always_ff @(posedge clk) begin
      if (rst)            ivr_q <= IVR_RESET;
      else if (ivr_we[c]) ivr_q <= wdata;
    end
    assign ivr_flat[c*DW +: DW] = ivr_q;
  end

endmodule

// File: rtl/wrb_busy_timer.sv
module wrb_busy_timer #(
  parameter int CYC = 20,
  parameter int CW  = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= CW'(CYC);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/wrb_channel.sv
module wrb_channel #(
  parameter int DW = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_good,
  input  logic          recall,
  input  logic [DW-1:0] recall_val,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          shut,
  output logic [DW-1:0] wr_q,
  output logic [DW-1:0] code_q,
  output logic          shut_q
);

  always_ff @(posedge clk) begin
    if (rst)            wr_q <= MID;
    else if (!pwr_good) wr_q <= MID;
    else if (recall)    wr_q <= recall_val;
    else if (ld)        wr_q <= ld_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= MID;
      shut_q <= 1'b0;
    end else begin
      code_q <= shut ? '0 : wr_q;
      shut_q <= shut;
    end
  end

endmodule

// File: rtl/wiper_regbank.sv
module wiper_regbank
  import wrb_pkg::*;
#(
  parameter int DW = 8,
  parameter int NCH = 2,
  parameter int NGP = 13,
  parameter int AW = 5,
  parameter int BUSY_CYCLES = 2_000_000,
  parameter logic [DW-1:0] MID = 8'h80,
  parameter logic [DW-1:0] IVR_RESET = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic              rsp_refused,
  output logic [DW-1:0]     rsp_data,
  output logic [NCH*DW-1:0] wiper_code,
  output logic [NCH-1:0]    shdn,
  output logic              sdo_open_drain
);

  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GIW = (NGP > 1) ? $clog2(NGP) : 1;
  localparam logic [AW-1:0] A_GP_LO = AW'(NCH);
  localparam logic [AW-1:0] A_GP_HI = AW'(NCH + NGP - 1);
  localparam logic [AW-1:0] A_ACR   = AW'(1 << (AW - 1));

  // power sequencing
  logic pg_q, up, recall;
  always_ff @(posedge clk) begin
    if (rst) pg_q <= 1'b0;
    else     pg_q <= pwr_good;
  end
  assign up     = pg_q & pwr_good;
  assign recall = pwr_good & ~pg_q;

  // decode
  acr_t acr;
  logic busy;
  logic is_ch, is_gp, is_acr, acr_rd, refuse, acc;
  logic ch_we, gp_we, acr_we, nv_start;
  logic [CIW-1:0] ch_idx;
  logic [GIW-1:0] gp_idx;
  logic [NCH-1:0] ld, ivr_we;

  assign is_ch   = req_addr < A_GP_LO;
  assign is_gp   = (req_addr >= A_GP_LO) && (req_addr <= A_GP_HI);
  assign is_acr  = req_addr == A_ACR;
  assign acr_rd  = !req_write && is_acr;
  assign refuse  = !up || (busy && !acr_rd) || (is_gp && acr.vol);
  assign acc     = req_valid && !refuse;
  assign ch_we   = acc && req_write && is_ch;
  assign gp_we   = acc && req_write && is_gp;
  assign acr_we  = acc && req_write && is_acr;
  assign nv_start = gp_we || (ch_we && !acr.vol);
  assign ch_idx  = req_addr[CIW-1:0];
  assign gp_idx  = GIW'(req_addr - A_GP_LO);

  for (genvar c = 0; c < NCH; c++) begin : g_we
    assign ld[c]     = ch_we && (ch_idx == CIW'(c));
    assign ivr_we[c] = ld[c] && !acr.vol;
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst)         acr <= ACR_RESET;
    else if (acr_we) acr <= '{vol: req_wdata[7], run: req_wdata[6], od: req_wdata[1]};
  end
  assign sdo_open_drain = acr.od;

  // persistent store and busy timer
  logic [NCH*DW-1:0] ivr_flat;
  logic [DW-1:0]     gp_rdata;
  logic [NCH-1:0][DW-1:0] ivr_arr;
  logic [NCH-1:0][DW-1:0] wr_arr;
  logic [NCH*DW-1:0] wr_flat;

  wrb_nv_store #(
    .DW(DW), .NCH(NCH), .NGP(NGP), .GIW(GIW), .IVR_RESET(IVR_RESET)
  ) u_nv (
    .clk(clk), .rst(rst), .ivr_we(ivr_we), .gp_we(gp_we), .gp_idx(gp_idx),
    .wdata(req_wdata), .ivr_flat(ivr_flat), .gp_rdata(gp_rdata)
  );
  assign ivr_arr = ivr_flat;

  wrb_busy_timer #(.CYC(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(nv_start), .busy(busy)
  );

  // channels
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] code_c;
    logic          shut_c;
    wrb_channel #(.DW(DW), .MID(MID)) u_ch (
      .clk(clk), .rst(rst), .pwr_good(pwr_good), .recall(recall),
      .recall_val(ivr_arr[c]), .ld(ld[c]), .ld_val(req_wdata),
      .shut(!acr.run), .wr_q(wr_arr[c]), .code_q(code_c), .shut_q(shut_c)
    );
    assign wiper_code[c*DW +: DW] = code_c;
    assign shdn[c] = shut_c;
  end
  assign wr_flat = wr_arr;

  // read path and response
  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (is_acr)     rd_val = DW'(acr_pack(acr, busy));
    else if (is_ch) rd_val = acr.vol ? wr_arr[ch_idx] : ivr_arr[ch_idx];
    else if (is_gp) rd_val = gp_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_refused <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_refused <= req_valid && refuse;
      rsp_data    <= (req_valid && !req_write && !refuse) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int DW = 8,
  parameter int NCH = 2,
  parameter int AW = 5,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_good,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic              rsp_refused,
  input logic [DW-1:0]     rsp_data,
  input logic [NCH*DW-1:0] wiper_code,
  input logic [NCH-1:0]    shdn,
  input logic              wip,
  input logic [NCH*DW-1:0] wr_flat
);

  localparam logic [AW-1:0] A_ACR = AW'(1 << (AW - 1));

  p_rsp_next_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_refused);

  p_busy_refuse_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && wip && !(!req_write && req_addr == A_ACR)) |=> rsp_refused);

  p_wip_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(req_valid && req_write));

  p_shdn_low_end_r9: assert property (@(posedge clk) disable iff (rst)
    shdn[0] |-> wiper_code[DW-1:0] == '0);

  p_shdn_low_end_last_r9: assert property (@(posedge clk) disable iff (rst)
    shdn[NCH-1] |-> wiper_code[(NCH-1)*DW +: DW] == '0);

  p_power_mid_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> wr_flat[DW-1:0] == MID);

  p_refused_zero_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_refused |-> rsp_data == '0);

  p_acr_zero_bits_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(req_valid && !req_write && req_addr == A_ACR) && rsp_valid && !rsp_refused)
      |-> (rsp_data[4:2] == 3'b000 && rsp_data[0] == 1'b0));

endmodule

bind wiper_regbank wrb_checker #(.DW(DW), .NCH(NCH), .AW(AW), .MID(MID)) u_chk (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_refused(rsp_refused), .rsp_data(rsp_data), .wiper_code(wiper_code),
  .shdn(shdn), .wip(busy), .wr_flat(wr_flat)
);

// File: tb/sim_wiper_regbank.sv
module sim_wiper_regbank;
  localparam int DW = 8, NCH = 2, NGP = 13, AW = 5, BUSY = 20;

  logic clk = 1'b0, rst = 1'b1, pwr_good = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, rsp_refused, sdo_open_drain;
  logic [DW-1:0] rsp_data;
  logic [NCH*DW-1:0] wiper_code;
  logic [NCH-1:0] shdn;

  wiper_regbank #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_refused(rsp_refused), .rsp_data(rsp_data),
    .wiper_code(wiper_code), .shdn(shdn), .sdo_open_drain(sdo_open_drain)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [7:0] m_ivr [NCH];
  logic [7:0] m_wr  [NCH];
  logic [7:0] m_gp  [NGP];
  logic m_vol = 1'b0, m_run = 1'b1, m_od = 1'b0, m_up = 1'b1;
  int m_last_nv = -100000;

  function automatic bit m_busy(int e);
    return (e - m_last_nv) <= BUSY;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_apply(bit w, logic [4:0] a, logic [7:0] d, int e,
                             output bit refd, output logic [7:0] dat);
    bit busy = m_busy(e);
    bit is_acr = (a == 5'd16);
    refd = !m_up || (busy && !(!w && is_acr)) || (a >= 2 && a <= 14 && m_vol);
    dat = 8'h00;
    if (!refd) begin
      if (is_acr) begin
        if (w) begin m_vol = d[7]; m_run = d[6]; m_od = d[1]; end
        else dat = {m_vol, m_run, busy, 3'b000, m_od, 1'b0};
      end else if (a < 2) begin
        if (w) begin
          if (m_vol) m_wr[a] = d;
          else begin m_ivr[a] = d; m_wr[a] = d; m_last_nv = e; end
        end else dat = m_vol ? m_wr[a] : m_ivr[a];
      end else if (a <= 14) begin
        if (w) begin m_gp[a-2] = d; m_last_nv = e; end
        else dat = m_gp[a-2];
      end
    end
  endtask

  task automatic chk_out(string tag);
    for (int c = 0; c < NCH; c++)
      check(tag, wiper_code[c*DW +: DW], m_run ? m_wr[c] : 8'h00, "wiper code");
    check(tag, shdn, m_run ? 2'b00 : 2'b11, "shutdown flags");
    check(tag, sdo_open_drain, m_od, "output type");
  endtask

  task automatic do_req(bit w, logic [4:0] a, logic [7:0] d, string tag);
    int e;
    bit refd;
    logic [7:0] dat;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e = cyc;
    model_apply(w, a, d, e, refd, dat);
    check(tag, rsp_valid, 1, "response valid");
    check(tag, rsp_refused, refd, "refused");
    if (!w) check(tag, rsp_data, dat, "read data");
    @(negedge clk);
    chk_out(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin m_ivr[c] = 8'h80; m_wr[c] = 8'h80; end
    for (int g = 0; g < NGP; g++) m_gp[g] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk_out("R1");
    do_req(0, 5'h10, 8'h00, "R1");

    // R2: live registers, extremes
    do_req(1, 5'h10, 8'hC0, "R2");
    do_req(1, 5'h00, 8'h11, "R2");
    do_req(1, 5'h01, 8'hEE, "R2");
    do_req(0, 5'h00, 8'h00, "R2");
    do_req(0, 5'h01, 8'h00, "R2");
    do_req(1, 5'h00, 8'h00, "R2");
    do_req(1, 5'h01, 8'hFF, "R2");
    do_req(0, 5'h10, 8'h00, "R2");
    do_req(1, 5'h00, 8'h11, "R2");

    // R6: general-purpose refused with bank-select 1
    do_req(0, 5'h02, 8'h00, "R6");
    do_req(1, 5'h0E, 8'h77, "R6");

    // R11: start-up read leaves live wiper
    do_req(1, 5'h10, 8'h40, "R11");
    do_req(0, 5'h00, 8'h00, "R11");
    do_req(0, 5'h01, 8'h00, "R11");

    // R3, R4, R5: persistent write then busy window
    do_req(1, 5'h00, 8'h5A, "R3");
    do_req(1, 5'h01, 8'h44, "R5");
    do_req(0, 5'h02, 8'h00, "R5");
    do_req(1, 5'h10, 8'hC0, "R5");
    for (int i = 0; i < 12; i++) do_req(0, 5'h10, 8'h00, "R4");
    do_req(0, 5'h00, 8'h00, "R3");

    // R6: general-purpose storage
    do_req(1, 5'h02, 8'hA5, "R6");
    for (int i = 0; i < 12; i++) do_req(0, 5'h10, 8'h00, "R4");
    do_req(1, 5'h0E, 8'h3C, "R6");
    repeat (BUSY) @(negedge clk);
    do_req(0, 5'h02, 8'h00, "R6");
    do_req(0, 5'h0E, 8'h00, "R6");

    // R7: reserved and undecoded
    do_req(1, 5'h0F, 8'h99, "R7");
    do_req(0, 5'h0F, 8'h00, "R7");
    do_req(1, 5'h1F, 8'h99, "R7");
    do_req(0, 5'h1F, 8'h00, "R7");
    do_req(0, 5'h11, 8'h00, "R7");

    // R8: control layout, write-in-progress not writable
    do_req(1, 5'h10, 8'hFF, "R8");
    do_req(0, 5'h10, 8'h00, "R8");
    do_req(1, 5'h10, 8'hC0, "R8");

    // R9: shutdown and restore
    do_req(1, 5'h10, 8'h80, "R9");
    do_req(1, 5'h01, 8'h66, "R9");
    do_req(1, 5'h10, 8'hC0, "R9");

    // R10: power cycle with recall
    do_req(1, 5'h10, 8'h40, "R10");
    do_req(1, 5'h01, 8'h37, "R10");
    repeat (BUSY) @(negedge clk);
    do_req(1, 5'h10, 8'hC0, "R10");
    do_req(1, 5'h01, 8'h99, "R10");
    @(negedge clk);
    pwr_good = 1'b0;
    m_up = 1'b0;
    for (int c = 0; c < NCH; c++) m_wr[c] = 8'h80;
    @(negedge clk); @(negedge clk);
    chk_out("R10");
    do_req(1, 5'h00, 8'h12, "R10");
    do_req(0, 5'h10, 8'h00, "R10");
    pwr_good = 1'b1;
    @(negedge clk); @(negedge clk);
    m_up = 1'b1;
    for (int c = 0; c < NCH; c++) m_wr[c] = m_ivr[c];
    chk_out("R10");
    do_req(0, 5'h01, 8'h00, "R10");

    // R12: random mix against the model
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 22;
      logic [4:0] a;
      logic [7:0] d = 8'($urandom);
      bit w = 1'($urandom);
      if (r < 17)       a = 5'(r);
      else if (r < 20)  a = 5'h10;
      else              a = 5'($urandom % 32);
      if (a == 5'h10 && ($urandom % 4) != 0) d[6] = 1'b1;
      do_req(w, a, d, "R12");
      repeat ($urandom % 3) @(negedge clk);
    end

    finish_run();
  end

endmodule